// File: doc/BRIEF.md
# Multi-mode DMA transfer controller

This block copies a block of words between a peripheral stream port and a synchronous single-port memory, without the processor. Software programs four registers through a simple write port: the first memory address, the word count, and a control word that holds the direction and the bus-sharing mode. A write of the start bit then launches the job. From then on the controller runs alone. It asks for the shared bus with `bus_req` and moves a word only in a cycle where `bus_gnt` is high. It sets a sticky completion interrupt once the last word has been handled.

There are three bus-sharing modes. Burst mode keeps the bus for the whole block. Cycle-steal mode gives the bus back after every single word and asks again for the next one. Idle-slot mode moves a word only in cycles that the processor flags as idle on `cpu_idle`.

Both peripheral ports use valid/ready rules. A word passes on a clock edge where valid and ready are both high. A source must hold `in_valid` and `in_data` until the word is accepted. The controller holds `out_valid` and `out_data` until `out_ready` takes the word. Back-pressure on the peripheral side never drops or reorders a word. A stalled peripheral keeps the bus only in burst mode.

Top module: `dma_xfer_ctrl`

## Requirements
- R1: The register offsets on `cfg_sel` are as follows. Offset 0 is the start address and offset 1 is the word count. Offset 2 is the control word: bit 0 is the direction, bits 2:1 are the mode (0 burst, 1 cycle-steal, 2 idle-slot, 3 acts as burst). Offset 3 is the command word: bit 0 starts a job, and writing 1 to bit 1 clears the interrupt. A start takes a snapshot of the registers as they stand.
- R2: A start with a nonzero count drives `busy` high from the next cycle. `busy` stays high until the clock edge that completes the last word. At that edge `busy` falls and `irq` rises.
- R3: A start with a count of zero raises `irq` on the next cycle. `busy` stays low and `bus_req` never rises.
- R4: `irq` stays high until a command write with bit 1 set. If a completion and a clear fall in the same cycle, the completion wins.
- R5: While `busy` is high, writes to offsets 0 to 2 and the start bit have no effect. The interrupt clear still works.
- R6: Direction 0 (peripheral to memory): a word taken on `in_valid && in_ready` is written to memory in the same cycle, at the current address. The address then steps by one.
- R7: Direction 1 (memory to peripheral): memory reads have a latency of one cycle. Words appear on the output port in address order. `out_data` stays stable while `out_valid` is high and `out_ready` is low.
- R8: In burst mode, `bus_req` stays high from the start until the last memory access. With a granted bus and a peripheral that is always ready, the memory accesses fall in consecutive cycles. A peripheral stall keeps the bus.
- R9: In cycle-steal mode, `bus_req` is low in the cycle after each memory access.
- R10: In idle-slot mode, a memory access happens only in a cycle with `cpu_idle` high.
- R11: A memory access happens only in a cycle where `bus_gnt` is high.
- R12: In cycle-steal and idle-slot modes, with direction 0, `bus_req` is high only while `in_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register offset |
| cfg_wdata | input | RW | Register write data |
| busy | output | 1 | Job in progress |
| irq | output | 1 | Sticky completion interrupt |
| bus_req | output | 1 | Shared-bus request |
| bus_gnt | input | 1 | Shared-bus grant |
| cpu_idle | input | 1 | Processor leaves the bus unused this cycle |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, one cycle after the read |
| in_valid | input | 1 | Peripheral source word valid |
| in_ready | output | 1 | Controller accepts the source word |
| in_data | input | DW | Peripheral source word |
| out_valid | output | 1 | Word offered to the peripheral sink |
| out_ready | input | 1 | Sink takes the word |
| out_data | output | DW | Word offered to the sink |

## Verification
The assertions check the per-cycle rules on every clock. These are the release after each stolen word, the idle-only access in idle-slot mode, the held request in burst mode, the address step, the stable output word under back-pressure, the sticky interrupt, the frozen registers while busy and the quiet completion of a zero-count job. Only the bench scenarios can show the rest. That covers the data itself: that every word reaches the right address, or arrives at the sink in order and intact, across stalls of the grant, the source and the sink. It also covers that burst mode really moves words in consecutive cycles, and that writes ignored while busy leave no trace on a later job started without reprogramming.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;

  typedef enum logic [1:0] {
    XM_BURST = 2'd0,
    XM_STEAL = 2'd1,
    XM_IDLE  = 2'd2,
    XM_RSVD  = 2'd3
  } xfer_mode_e;

  typedef struct packed {
    xfer_mode_e mode;
    logic       to_per;
  } xfer_ctrl_t;

  localparam logic [1:0] RS_ADDR  = 2'd0;
  localparam logic [1:0] RS_COUNT = 2'd1;
  localparam logic [1:0] RS_CTRL  = 2'd2;
  localparam logic [1:0] RS_CMD   = 2'd3;

  localparam int CMD_GO_BIT  = 0;
  localparam int CMD_CLR_BIT = 1;

endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
  import dma_xfer_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int RW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [RW-1:0] cfg_wdata,
  input  logic          busy,
  input  logic          done,
  output logic          start,
  output logic [AW-1:0] job_addr,
  output logic [CW-1:0] job_cnt,
  output xfer_ctrl_t    job_ctrl,
  output logic          irq
);

  logic wr_ok;
  logic clr_req;
  logic zero_done;
  logic unused_cfg;

  assign unused_cfg = ^cfg_wdata;
  assign wr_ok      = cfg_we && !busy;
  assign start      = wr_ok && (cfg_sel == RS_CMD) && cfg_wdata[CMD_GO_BIT];
  assign clr_req    = cfg_we && (cfg_sel == RS_CMD) && cfg_wdata[CMD_CLR_BIT];
  assign zero_done  = start && (job_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      job_addr <= '0;
      job_cnt  <= '0;
      job_ctrl <= '{mode: XM_BURST, to_per: 1'b0};
    end else if (wr_ok) begin
      case (cfg_sel)
        RS_ADDR:  job_addr <= cfg_wdata[AW-1:0];
        RS_COUNT: job_cnt  <= cfg_wdata[CW-1:0];
        RS_CTRL: begin
          job_ctrl.to_per <= cfg_wdata[0];
          job_ctrl.mode   <= xfer_mode_e'(cfg_wdata[2:1]);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 irq <= 1'b0;
    else if (done || zero_done) irq <= 1'b1;
    else if (clr_req)           irq <= 1'b0;
  end

  // R4: sticky interrupt
  a_r4_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !clr_req |=> irq);
  // R5: programming frozen during a job
  a_r5_regs_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(job_addr) && $stable(job_cnt) && $stable(job_ctrl));
  // R3: empty job completes at once
  a_r3_zero_done: assert property (@(posedge clk) disable iff (!rst_n)
    start && (job_cnt == '0) |=> irq && !busy);

endmodule

// File: rtl/dma_wbuf.sv
module dma_wbuf #(
  parameter int DW    = 32,
  parameter int DEPTH = 2,
  parameter int OW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic [OW-1:0] occ,
  output logic          pop
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] slot [DEPTH];
  logic [PW-1:0] wp, rp;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign out_valid = (occ != '0);
  assign out_data  = slot[rp];
  assign pop       = out_valid && out_ready;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && (wp == PW'(i))) slot[i] <= push_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      occ <= '0;
    end else begin
      if (push) wp <= step(wp);
      if (pop)  rp <= step(rp);
      occ <= occ + OW'(push) - OW'(pop);
    end
  end

  // R7: offered word held under back-pressure
  a_r7_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  // R7: no word lost to overflow
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (occ < OW'(DEPTH)) || pop);

endmodule

// File: rtl/dma_sequencer.sv
module dma_sequencer
  import dma_xfer_pkg::*;
#(
  parameter int AW    = 16,
  parameter int CW    = 16,
  parameter int DEPTH = 2,
  parameter int OW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] job_addr,
  input  logic [CW-1:0] job_cnt,
  input  xfer_ctrl_t    job_ctrl,
  input  logic          bus_gnt,
  input  logic          cpu_idle,
  input  logic          in_valid,
  input  logic [OW-1:0] buf_occ,
  input  logic          buf_pop,
  output logic          busy,
  output logic          done,
  output logic          bus_req,
  output logic          in_ready,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic          buf_push
);

  xfer_ctrl_t    ctl_q;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] bus_left;
  logic [CW-1:0] cnt_left;
  logic          rd_pend;
  logic          drop_q;

  logic          is_steal, is_idle_m, is_burst, to_per;
  logic [OW:0]   fill;
  logic          room, want, need, owned;
  logic          wr_mv, rd_mv, access, complete;

  always_comb begin
    is_steal  = (ctl_q.mode == XM_STEAL);
    is_idle_m = (ctl_q.mode == XM_IDLE);
    is_burst  = !is_steal && !is_idle_m;
    to_per    = ctl_q.to_per;
    fill      = {1'b0, buf_occ} + (OW+1)'(rd_pend) - (OW+1)'(buf_pop);
    room      = fill < (OW+1)'(DEPTH);
    want      = to_per ? room : in_valid;
    need      = busy && (bus_left != '0);
    bus_req   = need && (is_burst || (want && !drop_q));
    owned     = bus_req && bus_gnt && (!is_idle_m || cpu_idle);
    wr_mv     = owned && !to_per && in_valid;
    rd_mv     = owned && to_per && room;
    access    = wr_mv || rd_mv;
    in_ready  = owned && !to_per;
    complete  = to_per ? buf_pop : wr_mv;
    done      = busy && complete && (cnt_left == CW'(1));
  end

  assign mem_en   = access;
  assign mem_we   = wr_mv;
  assign mem_addr = addr_q;
  assign buf_push = rd_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      ctl_q    <= '{mode: XM_BURST, to_per: 1'b0};
      addr_q   <= '0;
      bus_left <= '0;
      cnt_left <= '0;
      rd_pend  <= 1'b0;
      drop_q   <= 1'b0;
    end else if (!busy) begin
      rd_pend <= 1'b0;
      drop_q  <= 1'b0;
      if (start && (job_cnt != '0)) begin
        busy     <= 1'b1;
        ctl_q    <= job_ctrl;
        addr_q   <= job_addr;
        bus_left <= job_cnt;
        cnt_left <= job_cnt;
      end
    end else begin
      rd_pend <= rd_mv;
      drop_q  <= is_steal && access;
      if (access) begin
        addr_q   <= addr_q + AW'(1);
        bus_left <= bus_left - CW'(1);
      end
      if (complete) cnt_left <= cnt_left - CW'(1);
      if (done)     busy     <= 1'b0;
    end
  end

  // R9: bus given back after each stolen word
  a_r9_give_back: assert property (@(posedge clk) disable iff (!rst_n)
    busy && is_steal && mem_en |=> !bus_req);
  // R10: idle-slot accesses only in idle cycles
  a_r10_idle_slot: assert property (@(posedge clk) disable iff (!rst_n)
    busy && is_idle_m && mem_en |-> cpu_idle);
  // R8: burst keeps the request until the last access
  a_r8_hold_bus: assert property (@(posedge clk) disable iff (!rst_n)
    busy && is_burst && bus_req && !(mem_en && bus_left == CW'(1)) |=> bus_req);
  // R6: address steps by one per access
  a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    busy && mem_en |=> addr_q == $past(addr_q) + AW'(1));
  // R2: busy holds until completion
  a_r2_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> busy);
  // R12: no idle request in shared modes
  a_r12_no_spare_req: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !is_burst && !to_per && bus_req |-> in_valid);
  // R11: no access without grant
  a_r11_grant: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> bus_gnt);

endmodule

// File: rtl/dma_xfer_ctrl.sv
module dma_xfer_ctrl
  import dma_xfer_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 32,
  parameter int CW        = 16,
  parameter int RW        = 32,
  parameter int BUF_DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [RW-1:0] cfg_wdata,
  output logic          busy,
  output logic          irq,
  output logic          bus_req,
  input  logic          bus_gnt,
  input  logic          cpu_idle,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);

  localparam int OW = $clog2(BUF_DEPTH + 1);

  logic          start, done, buf_push, buf_pop;
  logic [AW-1:0] job_addr;
  logic [CW-1:0] job_cnt;
  xfer_ctrl_t    job_ctrl;
  logic [OW-1:0] buf_occ;

  assign mem_wdata = in_data;

  dma_cfg_regs #(.AW(AW), .CW(CW), .RW(RW)) u_regs (
    .clk, .rst_n, .cfg_we, .cfg_sel, .cfg_wdata,
    .busy, .done, .start, .job_addr, .job_cnt, .job_ctrl, .irq
  );

  dma_sequencer #(.AW(AW), .CW(CW), .DEPTH(BUF_DEPTH), .OW(OW)) u_seq (
    .clk, .rst_n, .start, .job_addr, .job_cnt, .job_ctrl,
    .bus_gnt, .cpu_idle, .in_valid, .buf_occ, .buf_pop,
    .busy, .done, .bus_req, .in_ready, .mem_en, .mem_we, .mem_addr, .buf_push
  );

  dma_wbuf #(.DW(DW), .DEPTH(BUF_DEPTH), .OW(OW)) u_buf (
    .clk, .rst_n, .push(buf_push), .push_data(mem_rdata), .out_ready,
    .out_valid, .out_data, .occ(buf_occ), .pop(buf_pop)
  );

  // R1: a job never starts while another runs
  a_r1_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start);

endmodule

// File: tb/sim_dma_xfer_ctrl.sv
`timescale 1ns/1ps
module sim_dma_xfer_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        busy, irq, bus_req, mem_en, mem_we, in_ready, out_valid;
  logic        bus_gnt = 1'b0, cpu_idle = 1'b0, in_valid = 1'b0, out_ready = 1'b0;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata, out_data;
  logic [31:0] mem_rdata = '0, in_data = '0;

  always #4 clk = ~clk;

  dma_xfer_ctrl u0 (
    .clk, .rst_n, .cfg_we, .cfg_sel, .cfg_wdata, .busy, .irq, .bus_req,
    .bus_gnt, .cpu_idle, .mem_en, .mem_we, .mem_addr, .mem_wdata, .mem_rdata,
    .in_valid, .in_ready, .in_data, .out_valid, .out_ready, .out_data
  );

  int total = 0, bad = 0, cyc = 0;
  logic [31:0] mem_m [64];
  logic [31:0] src_q[$];
  logic [15:0] exp_a_q[$];
  logic [31:0] exp_d_q[$];
  logic [31:0] exp_o_q[$];
  int gm = 0, im = 0, vg = 0, rg = 0;
  int viol = 0, acc_n = 0, acc_first = 0, acc_last = 0;
  bit chk_steal = 0, chk_idle = 0, chk_burst = 0, req_seen = 0, prev_acc = 0;

  function automatic bit pat(int m, int c);
    case (m)
      0: return 1'b1;
      1: return (c % 3) != 0;
      2: return (c % 4) == 1 || (c % 4) == 2;
      default: return (c % 5) < 2;
    endcase
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor, memory model and peripheral models
  initial begin
    logic sw, sr, shi, sho;
    logic [15:0] sa;
    logic [31:0] sd;
    forever begin
      @(negedge clk);
      cyc++;
      sw = mem_en && mem_we; sr = mem_en && !mem_we;
      sa = mem_addr; sd = mem_wdata;
      shi = in_valid && in_ready; sho = out_valid && out_ready;
      if (bus_req) req_seen = 1;
      if (sw) begin
        if (exp_a_q.size() == 0) chk(0, "R6", {16'h0, sa, sd}, 64'h0);
        else begin
          logic [15:0] ea; logic [31:0] ed;
          ea = exp_a_q.pop_front(); ed = exp_d_q.pop_front();
          chk(sa == ea && sd == ed, "R6", {16'h0, sa, sd}, {16'h0, ea, ed});
        end
      end
      if (sho) begin
        if (exp_o_q.size() == 0) chk(0, "R7", {32'h0, out_data}, 64'h0);
        else begin
          logic [31:0] eo;
          eo = exp_o_q.pop_front();
          chk(out_data == eo, "R7", {32'h0, out_data}, {32'h0, eo});
        end
      end
      if (mem_en && !bus_gnt) viol++;                  // R11
      if (chk_steal && prev_acc && bus_req) viol++;     // R9
      if (chk_idle && mem_en && !cpu_idle) viol++;      // R10
      if (chk_burst && req_seen && busy && !bus_req && (acc_n < 1 || bus_req == 1'b0) &&
          exp_a_q.size() + exp_o_q.size() > 0 && !(u0.out_valid)) viol += 0;
      if (chk_burst && req_seen && busy && !bus_req && exp_a_q.size() > 0) viol++; // R8
      if (mem_en) begin
        if (acc_n == 0) acc_first = cyc;
        acc_last = cyc;
        acc_n++;
      end
      prev_acc = mem_en;
      if (cyc > 100000) begin
        chk(0, "watchdog", 64'(cyc), 64'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
      @(posedge clk); #1;
      if (sw) mem_m[sa[5:0]] = sd;
      if (sr) mem_rdata = mem_m[sa[5:0]];
      if (shi) void'(src_q.pop_front());
      if (!(in_valid && !shi)) in_valid = (src_q.size() > 0) && pat(vg, cyc);
      in_data   = (src_q.size() > 0) ? src_q[0] : 32'h0;
      out_ready = pat(rg, cyc);
      bus_gnt   = pat(gm, cyc);
      cpu_idle  = pat(im, cyc);
    end
  end

  task automatic cfg_wr(logic [1:0] sel, logic [31:0] d);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic launch(logic [15:0] a, int n, int mode, bit dir);
    cfg_wr(2'd0, 32'(a));
    cfg_wr(2'd1, 32'(n));
    cfg_wr(2'd2, 32'({mode[1:0], dir}));
    cfg_wr(2'd3, 32'h1);
    @(negedge clk);
    chk(busy == 1'b1, "R2", 64'(busy), 64'h1);
  endtask

  task automatic wait_idle(string r);
    int k = 0;
    while (busy && k < 2000) begin @(negedge clk); k++; end
    chk(!busy, r, 64'(busy), 64'h0);
  endtask

  task automatic finish_job(string r, int n);
    wait_idle(r);
    chk(irq == 1'b1, "R2", 64'(irq), 64'h1);
    chk(exp_a_q.size() == 0 && exp_o_q.size() == 0, r,
        64'(exp_a_q.size() + exp_o_q.size()), 64'h0);
    chk(acc_n == n, r, 64'(acc_n), 64'(n));
    chk(viol == 0, r, 64'(viol), 64'h0);
    cfg_wr(2'd3, 32'h2);
    @(negedge clk);
    chk(irq == 1'b0, "R4", 64'(irq), 64'h0);
    chk_steal = 0; chk_idle = 0; chk_burst = 0;
  endtask

  task automatic run_p2m(logic [15:0] a, int n, int mode, int g, int v, string r);
    gm = g; vg = v; viol = 0; acc_n = 0;
    for (int i = 0; i < n; i++) begin
      logic [31:0] d;
      d = 32'h5A00_0000 + 32'(a) * 32'h101 + 32'(i);
      src_q.push_back(d);
      exp_a_q.push_back(a + 16'(i));
      exp_d_q.push_back(d);
    end
    chk_steal = (mode == 1); chk_idle = (mode == 2); chk_burst = (mode == 0);
    req_seen = 0;
    launch(a, n, mode, 1'b0);
    finish_job(r, n);
  endtask

  task automatic load_m2p(logic [15:0] a, int n);
    for (int i = 0; i < n; i++) begin
      mem_m[(a + 16'(i)) & 16'h3F] = 32'hA500_0000 + 32'(a) + 32'(i) * 32'h11;
      exp_o_q.push_back(32'hA500_0000 + 32'(a) + 32'(i) * 32'h11);
    end
  endtask

  task automatic run_m2p(logic [15:0] a, int n, int mode, int g, int i_m, int r_m, string r);
    gm = g; im = i_m; rg = r_m; viol = 0; acc_n = 0;
    load_m2p(a, n);
    chk_steal = (mode == 1); chk_idle = (mode == 2); chk_burst = 0;
    launch(a, n, mode, 1'b1);
    finish_job(r, n);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk(busy == 0 && irq == 0, "R2", {busy, irq}, 64'h0);
    chk(bus_req == 0 && mem_en == 0, "R11", {bus_req, mem_en}, 64'h0);
    chk(out_valid == 0, "R7", 64'(out_valid), 64'h0);

    // R8: burst, peripheral to memory, back to back
    run_p2m(16'h10, 5, 0, 0, 0, "R8");
    chk(acc_last - acc_first == 4, "R8", 64'(acc_last - acc_first), 64'h4);
    // R8, R6: burst with source gaps keeps the bus
    run_p2m(16'h18, 4, 0, 0, 3, "R6");
    // R9, R12: cycle-steal with a slow grant and gaps
    run_p2m(16'h08, 4, 1, 1, 3, "R9");
    // R10, R7: idle-slot, memory to peripheral, sink stalls
    run_m2p(16'h20, 6, 2, 0, 2, 3, "R10");
    // R8, R7: burst memory to peripheral, back to back
    run_m2p(16'h28, 6, 0, 0, 0, 0, "R7");
    chk(acc_last - acc_first == 5, "R8", 64'(acc_last - acc_first), 64'h5);
    // R13-free mode 3 acts as burst (R1)
    run_p2m(16'h30, 3, 3, 0, 0, "R1");

    // R3: empty job
    req_seen = 0;
    cfg_wr(2'd1, 32'h0);
    cfg_wr(2'd3, 32'h1);
    @(negedge clk);
    chk(irq == 1 && busy == 0, "R3", {irq, busy}, 64'h2);
    repeat (3) @(negedge clk);
    chk(req_seen == 0, "R3", 64'(req_seen), 64'h0);
    repeat (8) @(negedge clk);
    chk(irq == 1, "R4", 64'(irq), 64'h1);
    cfg_wr(2'd3, 32'h2);

    // R5: writes while busy are ignored
    gm = 1; rg = 3; viol = 0; acc_n = 0; chk_steal = 1;
    load_m2p(16'h38, 4);
    launch(16'h38, 4, 1, 1'b1);
    cfg_wr(2'd0, 32'h4);
    cfg_wr(2'd1, 32'h9);
    cfg_wr(2'd2, 32'h0);
    cfg_wr(2'd3, 32'h1);
    wait_idle("R5");
    chk(acc_n == 4 && exp_o_q.size() == 0, "R5", 64'(acc_n), 64'h4);
    // restart without reprogramming; clear irq mid-job
    acc_n = 0;
    load_m2p(16'h38, 4);
    cfg_wr(2'd3, 32'h1);
    cfg_wr(2'd3, 32'h2);
    @(negedge clk);
    chk(irq == 0 && busy == 1, "R5", {irq, busy}, 64'h1);
    wait_idle("R5");
    chk(acc_n == 4 && exp_o_q.size() == 0 && irq == 1, "R5", 64'(acc_n), 64'h4);
    chk(viol == 0, "R9", 64'(viol), 64'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule